// File: doc/BRIEF.md
# PWM Fault Qualifier and Output Gate

This block sits between a free-running PWM generator and the output pins. Each of several active-high fault inputs passes through its own two-flop synchroniser and a small per-input qualifying state machine. When a fault is confirmed, the qualifier sets a sticky flag for that input. Software clears a flag by writing one to its bit. A programmable routing word decides which PWM outputs each flagged fault forces to zero. The generator upstream is never stopped: the block only gates the incoming waveforms.

The qualifier takes a sample on every fourth cycle in which the synchronised input is high. A programmable count setting chooses how many consecutive high samples confirm a fault: 1, 2, 3 or 4. A single interrupt request combines the flags with per-fault enables. Fault qualification and flagging run whether or not the PWM is in use. A fault seen while the PWM is idle therefore stays latched until software clears it.

Each qualifier has three states:
- QUAL_IDLE: the synchronised input is zero.
- QUAL_COUNT: the input is high and samples are being accumulated.
- QUAL_TRIP: a fault is confirmed.

It has five transitions:
- *arm*: QUAL_IDLE to QUAL_COUNT on a synchronised one. That cycle counts as the first of four.
- *sample*: QUAL_COUNT to QUAL_COUNT on each fourth high cycle that is not the last sample needed.
- *confirm*: QUAL_COUNT to QUAL_TRIP on the final sample.
- *abort*: QUAL_COUNT to QUAL_IDLE on any synchronised zero.
- *release*: QUAL_TRIP to QUAL_IDLE on a synchronised zero.

The qualifier asserts its detect output for every cycle it spends in QUAL_TRIP.

Top module: `pwm_fault_gate`

## Requirements
- R1: After reset, every register reads zero: the count setting, the routing word, the flags and the enables. irq_o is low and pwm_o equals pwm_i.
- R2: The register port decodes addresses as follows, with reads returning zero-extended values:
  - Address 0 holds the 2-bit count setting in bits 1:0.
  - Address 1 holds the 24-bit routing word.
  - Address 2 holds the flags in bits 3:0.
  - Address 3 holds the interrupt enables in bits 3:0.
- R3: With count setting q, a fault input held high from before clock edge 1 sets its flag after edge 7+4q, and not after edge 6+4q.
- R4: A synchronised zero at any point before confirmation returns the qualifier to QUAL_IDLE and discards its count. Timing then restarts from the next high.
- R5: A flag stays set after its input returns low. Writing a one to a flag bit at address 2 clears that flag. Writing a zero leaves it unchanged.
- R6: When a fault is confirmed in the same cycle that software writes one to clear its flag, the flag stays set.
- R7: Bit 4*p+f of the routing word makes fault f force output p low. pwm_o[p] is zero while any routed flag is set and equals pwm_i[p] otherwise. An output is released on the edge that clears the last routed flag.
- R8: irq_o is the OR over f of flag[f] AND enable[f]. It stays high until the flag is cleared, the enable is cleared, or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fault_i | input | 4 | Raw active-high fault inputs |
| pwm_i | input | 6 | PWM waveforms from the generator |
| pwm_o | output | 6 | Gated PWM waveforms |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a confirmation landing in exactly the cycle of a write-one clear. The stimulus avoids that timing race by holding a fault input high until the qualifier is parked in QUAL_TRIP. Detect is then asserted every cycle, so any clear write necessarily collides with a set. The bench checks that the flag survives the write, then drops the input and checks that a later clear succeeds. A short low pulse injected one sample before confirmation shows that the partial count is discarded.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

    typedef enum logic [1:0] {
        QUAL_IDLE  = 2'd0,
        QUAL_COUNT = 2'd1,
        QUAL_TRIP  = 2'd2
    } qual_state_t;

    localparam int ADDR_W     = 2;
    localparam logic [ADDR_W-1:0] REG_CTRL  = 2'd0;
    localparam logic [ADDR_W-1:0] REG_ROUTE = 2'd1;
    localparam logic [ADDR_W-1:0] REG_FLAG  = 2'd2;
    localparam logic [ADDR_W-1:0] REG_IEN   = 2'd3;

endpackage

// File: rtl/pfg_sync.sv
module pfg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pfg_qualifier.sv
module pfg_qualifier
    import pfg_pkg::*;
#(
    parameter int SAMPLE_DIV = 4,
    parameter int QSEL_W     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_i,
    input  logic [QSEL_W-1:0] qsel_i,
    output logic              detect_o
);
    localparam int DIV_W = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SAMPLE_DIV - 1);

    qual_state_t       state_q, state_d;
    logic [DIV_W-1:0]  div_q, div_d;
    logic [QSEL_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= QUAL_IDLE;
            div_q   <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            div_q   <= div_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        div_d   = div_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            QUAL_IDLE: begin
                if (sync_i) begin          // arm
                    state_d = QUAL_COUNT;
                    div_d   = DIV_W'(1);
                    cnt_d   = '0;
                end
            end
            QUAL_COUNT: begin
                if (!sync_i) begin         // abort
                    state_d = QUAL_IDLE;
                    div_d   = '0;
                    cnt_d   = '0;
                end else if (div_q == DIV_LAST) begin
                    div_d = '0;
                    if (cnt_q == qsel_i) state_d = QUAL_TRIP;   // confirm
                    else                 cnt_d   = cnt_q + 1'b1; // sample
                end else begin
                    div_d = div_q + 1'b1;
                end
            end
            QUAL_TRIP: begin
                if (!sync_i) begin         // release
                    state_d = QUAL_IDLE;
                    div_d   = '0;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = QUAL_IDLE;
                div_d   = '0;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        detect_o = (state_q == QUAL_TRIP);
    end

    AST_LOW_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n) !sync_i |=> state_q == QUAL_IDLE); // R4
    AST_TRIP_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (state_q == QUAL_TRIP) |-> $past(sync_i)); // R3
endmodule

// File: rtl/pfg_regs.sv
module pfg_regs
    import pfg_pkg::*;
#(
    parameter int NUM_FAULTS = 4,
    parameter int NUM_PWM    = 6,
    parameter int QSEL_W     = 2,
    parameter int DATA_W     = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic [ADDR_W-1:0]             rd_addr,
    output logic [DATA_W-1:0]             rd_data,
    input  logic [NUM_FAULTS-1:0]         detect_i,
    output logic [NUM_FAULTS-1:0]         flag_o,
    output logic [NUM_FAULTS-1:0]         ien_o,
    output logic [NUM_FAULTS*NUM_PWM-1:0] route_o,
    output logic [QSEL_W-1:0]             qsel_o
);
    localparam int ROUTE_W = NUM_FAULTS * NUM_PWM;

    logic [NUM_FAULTS-1:0] flag_q, ien_q, clr_mask;
    logic [ROUTE_W-1:0]    route_q;
    logic [QSEL_W-1:0]     qsel_q;

    assign clr_mask = (wr_en && wr_addr == REG_FLAG) ? wr_data[NUM_FAULTS-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qsel_q  <= '0;
            route_q <= '0;
            ien_q   <= '0;
        end else if (wr_en) begin
            if (wr_addr == REG_CTRL)  qsel_q  <= wr_data[QSEL_W-1:0];
            if (wr_addr == REG_ROUTE) route_q <= wr_data[ROUTE_W-1:0];
            if (wr_addr == REG_IEN)   ien_q   <= wr_data[NUM_FAULTS-1:0];
        end
    end

    // set beats clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~clr_mask) | detect_i;
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            REG_CTRL:  rd_data[QSEL_W-1:0]     = qsel_q;
            REG_ROUTE: rd_data[ROUTE_W-1:0]    = route_q;
            REG_FLAG:  rd_data[NUM_FAULTS-1:0] = flag_q;
            REG_IEN:   rd_data[NUM_FAULTS-1:0] = ien_q;
            default:   rd_data = '0;
        endcase
    end

    assign flag_o  = flag_q;
    assign ien_o   = ien_q;
    assign route_o = route_q;
    assign qsel_o  = qsel_q;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n) (|detect_i) |=> ((flag_q & $past(detect_i)) == $past(detect_i))); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) ((~flag_q & $past(flag_q) & ~$past(clr_mask)) == '0)); // R5
endmodule

// File: rtl/pwm_fault_gate.sv
module pwm_fault_gate
    import pfg_pkg::*;
#(
    parameter int NUM_FAULTS  = 4,
    parameter int NUM_PWM     = 6,
    parameter int SAMPLE_DIV  = 4,
    parameter int QSEL_W      = 2,
    parameter int SYNC_STAGES = 2,
    parameter int DATA_W      = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_FAULTS-1:0] fault_i,
    input  logic [NUM_PWM-1:0]    pwm_i,
    output logic [NUM_PWM-1:0]    pwm_o,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  irq_o
);
    localparam int ROUTE_W = NUM_FAULTS * NUM_PWM;

    logic [NUM_FAULTS-1:0] sync_w, detect_w, flag_w, ien_w;
    logic [ROUTE_W-1:0]    route_w;
    logic [QSEL_W-1:0]     qsel_w;
    logic [NUM_PWM-1:0]    kill_w;

    for (genvar f = 0; f < NUM_FAULTS; f++) begin : g_fault
        pfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d_i   (fault_i[f]),
            .q_o   (sync_w[f])
        );
        pfg_qualifier #(.SAMPLE_DIV(SAMPLE_DIV), .QSEL_W(QSEL_W)) u_qual (
            .clk      (clk),
            .rst_n    (rst_n),
            .sync_i   (sync_w[f]),
            .qsel_i   (qsel_w),
            .detect_o (detect_w[f])
        );
    end

    pfg_regs #(
        .NUM_FAULTS (NUM_FAULTS),
        .NUM_PWM    (NUM_PWM),
        .QSEL_W     (QSEL_W),
        .DATA_W     (DATA_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .detect_i (detect_w),
        .flag_o   (flag_w),
        .ien_o    (ien_w),
        .route_o  (route_w),
        .qsel_o   (qsel_w)
    );

    for (genvar p = 0; p < NUM_PWM; p++) begin : g_gate
        assign kill_w[p] = |(flag_w & route_w[p*NUM_FAULTS +: NUM_FAULTS]);
    end

    assign pwm_o = pwm_i & ~kill_w;
    assign irq_o = |(flag_w & ien_w);

    AST_OUT_SUBSET: assert property (@(posedge clk) disable iff (!rst_n) ((pwm_o & ~pwm_i) == '0)); // R7
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (irq_o && !wr_en) |=> irq_o); // R8
endmodule

// File: tb/pwm_fault_gate_test.sv
module pwm_fault_gate_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  fault_i = '0;
    logic [5:0]  pwm_i = '0;
    logic [5:0]  pwm_o;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pwm_fault_gate uut (
        .clk(clk), .rst_n(rst_n), .fault_i(fault_i), .pwm_i(pwm_i), .pwm_o(pwm_o),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic edges(input int k);
        repeat (k) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        edges(1);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic settle_clear();
        logic [31:0] v;
        fault_i = '0;
        edges(5);
        wr(2'd2, 32'hF);
        rd(2'd2, v);
        chk("R5 cleanup flags", v, 32'h0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        pwm_i = 6'h2A;
        #1;
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R1 reset register", v, 32'h0);
        end
        chk("R1 reset irq", {31'h0, irq_o}, 32'h0);
        chk("R1 reset passthrough", {26'h0, pwm_o}, 32'h2A);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(2'd0, 32'hFFFF_FFFE);
        rd(2'd0, v); chk("R2 ctrl readback", v, 32'h2);
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, v); chk("R2 route readback", v, 32'h00FF_FFFF);
        wr(2'd3, 32'hFFFF_FFF5);
        rd(2'd3, v); chk("R2 ien readback", v, 32'h5);
        wr(2'd1, 32'h0); wr(2'd3, 32'h0); wr(2'd0, 32'h0);
    endtask

    task automatic t_timing(input int q, input int f);
        logic [31:0] v;
        wr(2'd0, 32'(q));
        fault_i[f] = 1'b1;
        edges(6 + 4*q);
        rd(2'd2, v); chk("R3 flag not yet set", v, 32'h0);
        edges(1);
        rd(2'd2, v); chk("R3 flag set on time", v, 32'h1 << f);
        settle_clear();
    endtask

    task automatic t_glitch();
        logic [31:0] v;
        wr(2'd0, 32'd1);
        fault_i[1] = 1'b1;
        edges(7);
        fault_i[1] = 1'b0;
        edges(1);
        fault_i[1] = 1'b1;
        edges(10);
        rd(2'd2, v); chk("R4 count discarded by low", v, 32'h0);
        edges(1);
        rd(2'd2, v); chk("R4 restart timing", v, 32'h2);
        settle_clear();
    endtask

    task automatic t_sticky_priority();
        logic [31:0] v;
        wr(2'd0, 32'd0);
        fault_i[2] = 1'b1;
        edges(8);
        rd(2'd2, v); chk("R6 flag set", v, 32'h4);
        wr(2'd2, 32'h4);
        rd(2'd2, v); chk("R6 set wins over clear", v, 32'h4);
        fault_i[2] = 1'b0;
        edges(5);
        rd(2'd2, v); chk("R5 sticky after input low", v, 32'h4);
        wr(2'd2, 32'hB);
        rd(2'd2, v); chk("R5 zero bit leaves flag", v, 32'h4);
        wr(2'd2, 32'h4);
        rd(2'd2, v); chk("R5 write one clears", v, 32'h0);
    endtask

    task automatic t_route();
        // fault0 -> out1, out4 ; fault2 -> out5
        wr(2'd0, 32'd0);
        wr(2'd1, (32'h1 << 4) | (32'h1 << 16) | (32'h1 << 22));
        pwm_i = 6'h3F;
        fault_i[0] = 1'b1;
        edges(8);
        fault_i[0] = 1'b0;
        edges(4);
        chk("R7 fault0 gates out1 out4", {26'h0, pwm_o}, 32'h2D);
        pwm_i = 6'h15; #1;
        chk("R7 ungated outputs follow input", {26'h0, pwm_o}, 32'h05);
        pwm_i = 6'h3F;
        fault_i[2] = 1'b1;
        edges(8);
        fault_i[2] = 1'b0;
        edges(4);
        chk("R7 two faults gate union", {26'h0, pwm_o}, 32'h0D);
        wr(2'd2, 32'h1);
        chk("R7 release on clear edge", {26'h0, pwm_o}, 32'h1F);
        wr(2'd2, 32'h4);
        chk("R7 all released", {26'h0, pwm_o}, 32'h3F);
        wr(2'd1, 32'h0);
    endtask

    task automatic t_irq();
        wr(2'd0, 32'd0);
        fault_i[3] = 1'b1;
        edges(8);
        fault_i[3] = 1'b0;
        edges(4);
        chk("R8 no irq without enable", {31'h0, irq_o}, 32'h0);
        wr(2'd3, 32'h7);
        chk("R8 other enables no irq", {31'h0, irq_o}, 32'h0);
        wr(2'd3, 32'h8);
        chk("R8 irq raised", {31'h0, irq_o}, 32'h1);
        edges(3);
        chk("R8 irq held", {31'h0, irq_o}, 32'h1);
        wr(2'd3, 32'h0);
        chk("R8 enable clear drops irq", {31'h0, irq_o}, 32'h0);
        wr(2'd3, 32'h8);
        chk("R8 irq back", {31'h0, irq_o}, 32'h1);
        wr(2'd2, 32'h8);
        chk("R8 flag clear drops irq", {31'h0, irq_o}, 32'h0);
    endtask

    initial begin
        edges(3);
        t_reset();
        rst_n = 1'b1;
        edges(2);
        t_reset();
        t_regs();
        t_timing(0, 0);
        t_timing(3, 3);
        t_timing(1, 2);
        t_glitch();
        t_sticky_priority();
        t_route();
        t_irq();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule